// File: doc/BRIEF.md
# Partial Reconfiguration Register Front End

This block is the software-facing front end of a partial reconfiguration engine. Software reaches it over a simple 64-bit register bus with separate read and write strobes. Through it, software resets the engine with a request and acknowledge handshake, picks the target region, opens a loading session and streams 32-bit configuration words into an internal queue. The queue feeds a downstream ready/valid sink.

Flow control works by credit. The status register reports how many queue entries are free, and every accepted word lowers that figure by one. Software marks the end of the stream with a completion bit. Hardware answers by clearing the start bit once the queue has drained, and that cleared bit is the acknowledge.

Faults latch in a sticky error register that software clears by writing ones. The faults are a push with no credit, a push outside a session, a completion with no session, and two external integrity pins (CRC and image compatibility).

Top module: `prcfg_regif`

## Requirements
- R1: Reads return data on `bus_rdata` with `bus_rvalid` high one cycle after the `bus_rd` strobe. The register offsets are:
  - 0x00: header, the `HDR_VAL` parameter
  - 0x08: control
  - 0x10: status
  - 0x18: data
  - 0x20: error
  - 0xA8: the `ID_HI` parameter
  - 0xB0: the `ID_LO` parameter

  Any other offset reads as zero.
- R2: Writes to the header, status and both ID registers change nothing.
- R3: Control bit 0 is the engine reset request, and while it is set `eng_rst` is high. Control bit 4 (acknowledge) reads 1 from the cycle after the request is seen, and reads 0 one cycle after the request is cleared. The request empties the queue and ends any session.
- R4: Control bits 9:7 hold a 3-bit region ID. It is rewritten on every control write, reads back, and drives `region_id`.
- R5: Writing 1 to control bit 12 opens a session, unless bit 0 is set in the same write. Bit 12 stays set until hardware clears it. Writing 1 to bit 13 during a session marks the stream complete. Hardware clears bits 12 and 13 together once the queue is empty.
- R6: Status bits 8:0 report the credit, which is `DEPTH` minus the queue occupancy.
- R7: A data write during an open, incomplete session with free credit queues the low 32 bits of the write data. Words leave on `sink_data` in order, one per cycle while `sink_ready` is high. While `sink_ready` is low, `sink_valid` and `sink_data` hold.
- R8: A data write during an open, incomplete session with zero credit is dropped and sets error bit 4 (overflow).
- R9: A data write with no session open, or after completion, is dropped and sets error bit 3 (protocol).
- R10: Writing 1 to control bit 13 with no session open sets error bit 0 (operation).
- R11: A high cycle on `crc_err_in` sets error bit 1. A high cycle on `compat_err_in` sets error bit 2.
- R12: Error bits are sticky. Writing a one to a bit clears only that bit, and a set in the same cycle wins over the clear.
- R13: Status bit 16 is busy, meaning a session is open, the queue holds words, or any error is set. Bits 22:20 give the controller state: 0 idle, 1 reset, 2 loading, 3 draining. Bits 27:24 give {complete, start, acknowledge, reset request}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid |
| eng_rst | output | 1 | Engine reset, follows control bit 0 |
| region_id | output | 3 | Selected region |
| crc_err_in | input | 1 | CRC fault pulse |
| compat_err_in | input | 1 | Image compatibility fault pulse |
| sink_valid | output | 1 | Queue head valid |
| sink_data | output | 32 | Queue head word |
| sink_ready | input | 1 | Sink accepts the head word |

## Verification
A write takes effect at the clock edge that samples it. A read samples state at its own strobe edge, and the data appears one cycle later. The reset acknowledge and the session release each land one edge after their cause. For that reason every bus write in the bench is followed by one idle cycle before the next read, so each read sees the settled result. The sink monitor samples a quarter period before each rising edge, which is when an accepted word transfers, and it compares against words the bench derives from their push index.

// File: rtl/prcfg_pkg.sv
package prcfg_pkg;

    localparam int ADDR_W  = 8;
    localparam int DATA_W  = 64;
    localparam int WORD_W  = 32;
    localparam int NUM_ERR = 5;
    localparam int RGN_W   = 3;
    localparam int CRED_W  = 9;
    localparam int HOST_W  = 4;

    // register offsets
    localparam logic [ADDR_W-1:0] OFS_HDR  = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_DATA = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_ERR  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_IDH  = 8'hA8;
    localparam logic [ADDR_W-1:0] OFS_IDL  = 8'hB0;

    // control field positions
    localparam int CB_RST    = 0;
    localparam int CB_ACK    = 4;
    localparam int CB_RGN_LO = 7;
    localparam int CB_START  = 12;
    localparam int CB_DONE   = 13;

    // status field positions
    localparam int SB_CRED_LO = 0;
    localparam int SB_BUSY    = 16;
    localparam int SB_CST_LO  = 20;
    localparam int SB_HOST_LO = 24;

    // error flag positions
    localparam int EB_OPER   = 0;
    localparam int EB_CRC    = 1;
    localparam int EB_COMPAT = 2;
    localparam int EB_PROTO  = 3;
    localparam int EB_OVF    = 4;

    typedef enum logic [2:0] {
        CS_IDLE  = 3'd0,
        CS_RESET = 3'd1,
        CS_LOAD  = 3'd2,
        CS_DRAIN = 3'd3
    } ctl_state_e;

    typedef struct packed {
        logic             rst_req;
        logic             rst_ack;
        logic [RGN_W-1:0] region;
        logic             start;
        logic             done;
    } ctrl_t;

    typedef struct packed {
        logic [CRED_W-1:0] credit;
        logic              busy;
        ctl_state_e        cstate;
        logic [HOST_W-1:0] host;
    } stat_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] v;
        v = '0;
        v[CB_RST]                = c.rst_req;
        v[CB_ACK]                = c.rst_ack;
        v[CB_RGN_LO +: RGN_W]    = c.region;
        v[CB_START]              = c.start;
        v[CB_DONE]               = c.done;
        return v;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(input stat_t s);
        logic [DATA_W-1:0] v;
        v = '0;
        v[SB_CRED_LO +: CRED_W]  = s.credit;
        v[SB_BUSY]               = s.busy;
        v[SB_CST_LO +: 3]        = s.cstate;
        v[SB_HOST_LO +: HOST_W]  = s.host;
        return v;
    endfunction

endpackage

// File: rtl/prcfg_fifo.sv
module prcfg_fifo #(
    parameter int DEPTH = 256,
    parameter int W     = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  push_data,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic          empty,
    output logic          full,
    output logic [CW-1:0] count
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic          do_push, do_pop;

    function automatic logic [AW-1:0] adv(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    assign empty   = (cnt_q == '0);
    assign full    = (cnt_q == CW'(DEPTH));
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rp_q];
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (do_push) wp_q <= adv(wp_q);
            if (do_pop)  rp_q <= adv(rp_q);
            case ({do_push, do_pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp_q] <= push_data;
    end

    // R6: occupancy never exceeds the queue depth
    p_count_bound_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CW'(DEPTH));

    // R7: a lone accepted push grows occupancy by exactly one
    p_push_grows_r7: assert property (@(posedge clk) disable iff (rst)
        (push && !full && !pop && !flush) |=> (cnt_q == CW'($past(cnt_q) + 1'b1)));

endmodule

// File: rtl/prcfg_session.sv
module prcfg_session
    import prcfg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_wr,
    input  logic             wr_rst,
    input  logic [RGN_W-1:0] wr_region,
    input  logic             wr_start,
    input  logic             wr_done,
    input  logic             fifo_empty,
    output ctrl_t            ctrl,
    output ctl_state_e       cstate,
    output logic             oper_err
);
    logic             rst_req_q, rst_ack_q, start_q, done_q;
    logic [RGN_W-1:0] region_q;
    logic             release_now;

    assign release_now = start_q && done_q && fifo_empty;

    always_ff @(posedge clk) begin
        if (rst) begin
            rst_req_q <= 1'b0;
            rst_ack_q <= 1'b0;
            region_q  <= '0;
            start_q   <= 1'b0;
            done_q    <= 1'b0;
        end else begin
            rst_ack_q <= rst_req_q;
            if (ctrl_wr) begin
                rst_req_q <= wr_rst;
                region_q  <= wr_region;
            end
            if (rst_req_q || release_now) begin
                start_q <= 1'b0;
                done_q  <= 1'b0;
            end else if (ctrl_wr) begin
                if (!start_q && wr_start && !wr_rst) start_q <= 1'b1;
                if (start_q && wr_done)              done_q  <= 1'b1;
            end
        end
    end

    assign oper_err = ctrl_wr && wr_done && !start_q;

    always_comb begin
        if (rst_req_q)            cstate = CS_RESET;
        else if (start_q && done_q) cstate = CS_DRAIN;
        else if (start_q)         cstate = CS_LOAD;
        else                      cstate = CS_IDLE;
    end

    assign ctrl = '{rst_req: rst_req_q, rst_ack: rst_ack_q, region: region_q,
                    start: start_q, done: done_q};

    // R5: start only drops after completion with an empty queue, or on engine reset
    p_start_release_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(start_q) |-> ($past(done_q && fifo_empty) || $past(rst_req_q)));

    // R3: a request held for two cycles is acknowledged
    p_ack_follow_r3: assert property (@(posedge clk) disable iff (rst)
        (rst_req_q && $past(rst_req_q)) |-> rst_ack_q);

    // R5: completion never stands without an open session
    p_done_needs_start_r5: assert property (@(posedge clk) disable iff (rst)
        done_q |-> start_q);

endmodule

// File: rtl/prcfg_errlog.sv
module prcfg_errlog #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set_vec,
    input  logic [N-1:0] clr_vec,
    output logic [N-1:0] flags
);
    logic [N-1:0] flags_q;

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)             flags_q[i] <= 1'b0;
            else if (set_vec[i]) flags_q[i] <= 1'b1;
            else if (clr_vec[i]) flags_q[i] <= 1'b0;
        end

        // R12: a flag stays set until a one is written to it
        p_sticky_r12: assert property (@(posedge clk) disable iff (rst)
            (flags_q[i] && !clr_vec[i]) |=> flags_q[i]);

        // R12: a set wins over a clear in the same cycle
        p_set_wins_r12: assert property (@(posedge clk) disable iff (rst)
            set_vec[i] |=> flags_q[i]);
    end

    assign flags = flags_q;

endmodule

// File: rtl/prcfg_regif.sv
module prcfg_regif
    import prcfg_pkg::*;
#(
    parameter int          DEPTH   = 256,
    parameter logic [63:0] HDR_VAL = 64'h0000_0001_0000_0010,
    parameter logic [63:0] ID_HI   = 64'h1357_9BDF_2468_ACE0,
    parameter logic [63:0] ID_LO   = 64'h0F1E_2D3C_4B5A_6978
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [63:0] bus_wdata,
    output logic [63:0] bus_rdata,
    output logic        bus_rvalid,
    output logic        eng_rst,
    output logic [2:0]  region_id,
    input  logic        crc_err_in,
    input  logic        compat_err_in,
    output logic        sink_valid,
    output logic [31:0] sink_data,
    input  logic        sink_ready
);
    localparam int CW = $clog2(DEPTH + 1);

    ctrl_t             ctrl;
    ctl_state_e        cstate;
    stat_t             stat;
    logic              oper_err;
    logic              wr_ctrl, wr_data, wr_err;
    logic              in_session, push_ok, proto_err, ovf_err;
    logic              q_empty, q_full;
    logic [CW-1:0]     q_count;
    logic [CW-1:0]     credit;
    logic [NUM_ERR-1:0] err_set, err_clr, err_flags;
    logic [DATA_W-1:0] rd_mux, rdata_q;
    logic              rvalid_q;
    logic              unused_hi;

    assign unused_hi = ^bus_wdata[63:32];

    // write decode
    assign wr_ctrl = bus_wr && (bus_addr == OFS_CTRL);
    assign wr_data = bus_wr && (bus_addr == OFS_DATA);
    assign wr_err  = bus_wr && (bus_addr == OFS_ERR);

    // push qualification
    assign in_session = ctrl.start && !ctrl.done;
    assign push_ok    = wr_data && in_session && !q_full;
    assign ovf_err    = wr_data && in_session && q_full;
    assign proto_err  = wr_data && !in_session;

    prcfg_session u_session (
        .clk        (clk),
        .rst        (rst),
        .ctrl_wr    (wr_ctrl),
        .wr_rst     (bus_wdata[CB_RST]),
        .wr_region  (bus_wdata[CB_RGN_LO +: RGN_W]),
        .wr_start   (bus_wdata[CB_START]),
        .wr_done    (bus_wdata[CB_DONE]),
        .fifo_empty (q_empty),
        .ctrl       (ctrl),
        .cstate     (cstate),
        .oper_err   (oper_err)
    );

    prcfg_fifo #(
        .DEPTH (DEPTH),
        .W     (WORD_W),
        .CW    (CW)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .flush     (ctrl.rst_req),
        .push      (push_ok),
        .push_data (bus_wdata[WORD_W-1:0]),
        .pop       (sink_ready),
        .head      (sink_data),
        .empty     (q_empty),
        .full      (q_full),
        .count     (q_count)
    );

    always_comb begin
        err_set            = '0;
        err_set[EB_OPER]   = oper_err;
        err_set[EB_CRC]    = crc_err_in;
        err_set[EB_COMPAT] = compat_err_in;
        err_set[EB_PROTO]  = proto_err;
        err_set[EB_OVF]    = ovf_err;
        err_clr            = wr_err ? bus_wdata[NUM_ERR-1:0] : '0;
    end

    prcfg_errlog #(
        .N (NUM_ERR)
    ) u_errlog (
        .clk     (clk),
        .rst     (rst),
        .set_vec (err_set),
        .clr_vec (err_clr),
        .flags   (err_flags)
    );

    // status assembly
    assign credit      = CW'(DEPTH) - q_count;
    assign stat.credit = CRED_W'(credit);
    assign stat.busy   = ctrl.start || !q_empty || (|err_flags);
    assign stat.cstate = cstate;
    assign stat.host   = {ctrl.done, ctrl.start, ctrl.rst_ack, ctrl.rst_req};

    // read mux
    always_comb begin
        case (bus_addr)
            OFS_HDR:  rd_mux = HDR_VAL;
            OFS_CTRL: rd_mux = pack_ctrl(ctrl);
            OFS_STAT: rd_mux = pack_stat(stat);
            OFS_ERR:  rd_mux = DATA_W'(err_flags);
            OFS_IDH:  rd_mux = ID_HI;
            OFS_IDL:  rd_mux = ID_LO;
            default:  rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= bus_rd;
            if (bus_rd) rdata_q <= rd_mux;
        end
    end

    assign bus_rdata  = rdata_q;
    assign bus_rvalid = rvalid_q;
    assign eng_rst    = ctrl.rst_req;
    assign region_id  = ctrl.region;
    assign sink_valid = !q_empty;

    // R8: a push into a full queue during a session latches overflow
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_data && ctrl.start && !ctrl.done && (credit == '0)) |=> err_flags[EB_OVF]);

    // R9: a push outside a session latches the protocol flag
    p_proto_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !ctrl.start) |=> err_flags[EB_PROTO]);

    // R7: a stalled head word holds
    p_sink_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (sink_valid && !sink_ready && !eng_rst) |=> (sink_valid && $stable(sink_data)));

    // R1: read data valid exactly one cycle after the strobe
    p_rvalid_r1: assert property (@(posedge clk) disable iff (rst)
        bus_rd |=> bus_rvalid);

endmodule

// File: tb/prcfg_regif_tb.sv
module prcfg_regif_tb_top;
    localparam int          CLK_P = 10;
    localparam int          DEPTH = 8;
    localparam logic [63:0] HDR   = 64'hA0B1_C2D3_0000_0042;
    localparam logic [63:0] IDH   = 64'h0123_4567_89AB_CDEF;
    localparam logic [63:0] IDL   = 64'hFEDC_BA98_7654_3210;
    localparam logic [7:0]  A_HDR = 8'h00, A_CTL = 8'h08, A_STS = 8'h10,
                            A_DAT = 8'h18, A_ERR = 8'h20, A_IDH = 8'hA8, A_IDL = 8'hB0;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [63:0] bus_wdata = '0;
    logic [63:0] bus_rdata;
    logic        bus_rvalid, eng_rst, sink_valid;
    logic [2:0]  region_id;
    logic [31:0] sink_data;
    logic        crc_err_in = 1'b0, compat_err_in = 1'b0, sink_ready = 1'b0;

    int checks = 0;
    int fails  = 0;
    int wr_idx = 0;
    int rx_idx = 0;
    logic [31:0] exp_words [16];

    always #(CLK_P/2) clk = ~clk;

    prcfg_regif #(.DEPTH(DEPTH), .HDR_VAL(HDR), .ID_HI(IDH), .ID_LO(IDL)) dut_i (
        .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .eng_rst(eng_rst), .region_id(region_id), .crc_err_in(crc_err_in),
        .compat_err_in(compat_err_in), .sink_valid(sink_valid), .sink_data(sink_data),
        .sink_ready(sink_ready));

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [63:0] st(input int cred, input int busy, input int cs, input int host);
        return 64'(cred) | (64'(busy) << 16) | (64'(cs) << 20) | (64'(host) << 24);
    endfunction

    function automatic logic [31:0] word_of(input int n);
        return 32'hA500_0000 + 32'(n) * 32'h0001_0101;
    endfunction

    task automatic bus_write(input logic [7:0] a, input logic [63:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [63:0] d, output logic v);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0; d = bus_rdata; v = bus_rvalid;
    endtask

    task automatic rchk(input string req, input logic [7:0] a, input logic [63:0] exp);
        logic [63:0] d;
        logic v;
        bus_read(a, d, v);
        chk(req, d, exp);
    endtask

    task automatic push(input int n, input bit keep);
        bus_write(A_DAT, {32'hDEAD_0000 | 32'(n), word_of(n)});
        if (keep) begin
            exp_words[wr_idx] = word_of(n);
            wr_idx++;
        end
    endtask

    // sink monitor, a quarter period before the accepting edge
    always begin
        @(negedge clk);
        #(CLK_P/4);
        if (!rst && sink_valid && sink_ready) begin
            chk("R7 sink order", 64'(sink_data), 64'(exp_words[rx_idx]));
            rx_idx++;
        end
    end

    initial begin
        #(CLK_P * 50000);
        checks++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [63:0] d;
        logic v;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset-state reads and the map
        bus_read(A_HDR, d, v);
        chk("R1 header", d, HDR);
        chk("R1 rvalid", 64'(v), 64'd1);
        rchk("R1 id high", A_IDH, IDH);
        rchk("R1 id low", A_IDL, IDL);
        rchk("R3 ctrl reset", A_CTL, 64'h0);
        rchk("R13 status reset", A_STS, st(DEPTH, 0, 0, 0));
        rchk("R12 err reset", A_ERR, 64'h0);
        rchk("R1 unmapped 0x40", 8'h40, 64'h0);
        rchk("R1 unmapped 0x28", 8'h28, 64'h0);
        chk("R7 sink idle", 64'(sink_valid), 64'd0);

        // R2 read-only writes
        bus_write(A_STS, '1);
        bus_write(A_HDR, 64'h0);
        bus_write(A_IDH, 64'h0);
        rchk("R2 status unchanged", A_STS, st(DEPTH, 0, 0, 0));
        rchk("R2 header unchanged", A_HDR, HDR);
        rchk("R2 id high unchanged", A_IDH, IDH);

        // R9 push before start
        push(99, 1'b0);
        rchk("R9 proto flag", A_ERR, 64'h08);
        chk("R9 nothing queued", 64'(sink_valid), 64'd0);
        rchk("R13 busy on error", A_STS, st(DEPTH, 1, 0, 0));
        bus_write(A_ERR, 64'h08);
        rchk("R12 w1c clear", A_ERR, 64'h0);

        // R3 reset handshake
        bus_write(A_CTL, 64'h1);
        chk("R3 eng_rst high", 64'(eng_rst), 64'd1);
        rchk("R3 ack set", A_CTL, 64'h11);
        rchk("R13 reset state", A_STS, st(DEPTH, 0, 1, 3));
        bus_write(A_CTL, 64'h0);
        chk("R3 eng_rst low", 64'(eng_rst), 64'd0);
        rchk("R3 ack dropped", A_CTL, 64'h0);

        // R4 R5 open session on region 5
        bus_write(A_CTL, 64'h1280);
        chk("R4 region pin", 64'(region_id), 64'd5);
        rchk("R5 ctrl start", A_CTL, 64'h1280);
        rchk("R13 load state", A_STS, st(DEPTH, 1, 2, 4));

        // R6 credit sweep across the whole queue
        for (int n = 0; n < DEPTH; n++) begin
            push(n, 1'b1);
            rchk("R6 credit sweep", A_STS, st(DEPTH - n - 1, 1, 2, 4));
        end
        chk("R7 head valid", 64'(sink_valid), 64'd1);

        // R8 overflow
        push(50, 1'b0);
        rchk("R8 overflow flag", A_ERR, 64'h10);
        rchk("R8 credit stays zero", A_STS, st(0, 1, 2, 4));
        chk("R7 head held", 64'(sink_data), 64'(word_of(0)));
        bus_write(A_ERR, 64'h10);

        // R5 completion while stalled
        bus_write(A_CTL, 64'h3280);
        rchk("R5 start held while queued", A_CTL, 64'h3280);
        rchk("R13 drain state", A_STS, st(0, 1, 3, 12));
        push(60, 1'b0);
        rchk("R9 push after complete", A_ERR, 64'h08);
        bus_write(A_ERR, 64'h08);

        // R5 R7 drain
        @(negedge clk); sink_ready = 1'b1;
        repeat (DEPTH + 4) @(negedge clk);
        chk("R7 words delivered", 64'(rx_idx), 64'(DEPTH));
        rchk("R5 start released", A_CTL, 64'h0280);
        rchk("R6 credit restored", A_STS, st(DEPTH, 0, 0, 0));

        // R10 complete with no session
        bus_write(A_CTL, 64'h2280);
        rchk("R10 oper flag", A_ERR, 64'h01);
        rchk("R10 no session", A_CTL, 64'h0280);

        // R11 R12 integrity pins and partial clears
        @(negedge clk); crc_err_in = 1'b1;
        @(negedge clk); crc_err_in = 1'b0;
        rchk("R11 crc flag", A_ERR, 64'h03);
        @(negedge clk); compat_err_in = 1'b1;
        @(negedge clk); compat_err_in = 1'b0;
        rchk("R11 compat flag", A_ERR, 64'h07);
        bus_write(A_ERR, 64'h02);
        rchk("R12 partial clear", A_ERR, 64'h05);
        @(negedge clk); crc_err_in = 1'b1;
        bus_write(A_ERR, 64'h02);
        @(negedge clk); crc_err_in = 1'b0;
        rchk("R12 set wins", A_ERR, 64'h07);
        bus_write(A_ERR, 64'h1F);
        rchk("R12 clear all", A_ERR, 64'h0);

        // R3 engine reset flushes a live session
        @(negedge clk); sink_ready = 1'b0;
        bus_write(A_CTL, 64'h1280);
        for (int n = 0; n < 3; n++) push(20 + n, 1'b1);
        rchk("R6 partial credit", A_STS, st(DEPTH - 3, 1, 2, 4));
        bus_write(A_CTL, 64'h0281);
        rchk("R3 flush credit", A_STS, st(DEPTH, 0, 1, 3));
        rchk("R3 session ended", A_CTL, 64'h0291);
        chk("R3 queue empty", 64'(sink_valid), 64'd0);
        bus_write(A_CTL, 64'h0280);
        rchk("R3 released", A_CTL, 64'h0280);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule